// File: doc/BRIEF.md
# Adaptive Dimension-Order Route Selector

This unit computes the route for each head flit in a router of a two-dimensional flattened butterfly. Every router serves `C` terminals. For each request it receives the local router number, the destination terminal, the input channel the flit arrived on, the flit's current virtual channel, its traffic class, and a used-credit count for every output port. It returns one output port and the window of virtual channels the flit may take there.

A flit can travel X-then-Y or Y-then-X. The order is fixed once, when the flit enters the network from a terminal channel. At that point the unit picks whichever of the two first-hop outputs currently holds fewer used credits. At later hops nothing records that choice except the half of the class's VC range the flit sits in. Keeping the two orders in separate VC halves is what keeps the mix of orders free of deadlock.

Requests are accepted with a valid/ready handshake. The result is registered and offered on a valid/ready output.

Top module: `ffly_route_sel`

## Requirements
- R1: When the destination terminal divided by C equals the local router number, the result is an ejection. The port is the destination modulo C, `rsp_eject` is 1, and the VC window is the whole class range.
- R2: The class codes on `req_cls` are 1 read request, 2 write request, 3 read reply and 4 write reply. Their default VC ranges are 0..3, 4..5, 6..7 and 4..7. Any other code may use every VC, 0..NVC-1.
- R3: A router's X coordinate is its number mod K and its Y coordinate is its number div K. A hop that fixes X uses port C+j. A hop that fixes Y uses port C+(K-1)+j. Here j is the peer's coordinate, reduced by one when it lies above the local coordinate.
- R4: XY order fixes X first whenever X differs, otherwise Y. YX order fixes Y first whenever Y differs, otherwise X. `rsp_xy` reports the order used, 1 for XY.
- R5: Let half be (class size)/2, using integer division. XY order gets the VC window lo..lo+half-1. YX order gets lo+half..hi.
- R6: On a terminal input channel (`req_in_chan` < C), the order whose candidate port has strictly fewer used credits is chosen.
- R7: On a terminal channel with equal credits, bit 0 of an internal 16-bit shift register picks the order (1 means XY). The register resets to 0xACE1 and shifts left on every accepted request. The bit shifted in is the XOR of bits 15, 13, 12 and 10.
- R8: On a network input channel (`req_in_chan` >= C), XY order applies exactly when `req_vc` < lo+half.
- R9: A request flagged `req_src_inject` gets no route. `rsp_no_route` is 1, the port is 0, and the VC window is the whole class range.
- R10: The result appears one cycle after an accepted request. `req_ready` equals `!rsp_valid || rsp_ready`. A result that has not been taken stays valid and unchanged.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_rtr | input | RW (4) | Local router number |
| req_dest | input | DW (5) | Destination terminal |
| req_in_chan | input | PW (3) | Input channel the flit arrived on |
| req_vc | input | VW (3) | Current VC of the flit |
| req_cls | input | 3 | Traffic class code |
| req_src_inject | input | 1 | Flit is being injected at its source interface |
| used_credits | input | NP*CW (32) | Used-credit count per output port, CW bits each |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle when valid |
| rsp_port | output | PW (3) | Chosen output port |
| rsp_vc_lo | output | VW (3) | Lowest allowed VC |
| rsp_vc_hi | output | VW (3) | Highest allowed VC |
| rsp_xy | output | 1 | 1 when XY order is in effect |
| rsp_eject | output | 1 | Output is an ejection port |
| rsp_no_route | output | 1 | No route produced |

## Verification
Two things can land on the same clock edge: a held result being drained, and a new request being accepted. The bench stalls the output with `rsp_ready` low while a second request waits. It checks that the first result stays unchanged and that `req_ready` stays low. It then raises `rsp_ready` with the second request still pending. The result seen one cycle later must belong to the second request, with no bubble between the two. The free-running tie-break register is predicted in the bench across both accepts.

// File: rtl/ffly_route_pkg.sv
package ffly_route_pkg;

    typedef enum logic [2:0] {
        CLS_ANY    = 3'd0,
        CLS_RD_REQ = 3'd1,
        CLS_WR_REQ = 3'd2,
        CLS_RD_RSP = 3'd3,
        CLS_WR_RSP = 3'd4
    } flit_cls_e;

    typedef enum logic [1:0] {
        WIN_FULL = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2
    } win_mode_e;

    localparam logic [15:0] TIE_SEED = 16'hACE1;

    // index of a peer among the k-1 routers of one dimension, own slot skipped
    function automatic int peer_slot(input int own, input int other);
        return (other < own) ? other : other - 1;
    endfunction

    function automatic logic [15:0] tie_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/ffly_port_calc.sv
module ffly_port_calc
    import ffly_route_pkg::*;
#(
    parameter int K  = 4,
    parameter int C  = 2,
    parameter int RW = 4,
    parameter int PW = 3
) (
    input  logic [RW-1:0] cur_rtr,
    input  logic [RW-1:0] dst_rtr,
    output logic [PW-1:0] port_xy,
    output logic [PW-1:0] port_yx,
    output logic          at_dest
);
    always_comb begin
        int cx, cy, dx, dy, px, py;
        cx = int'(cur_rtr) % K;
        cy = int'(cur_rtr) / K;
        dx = int'(dst_rtr) % K;
        dy = int'(dst_rtr) / K;
        px = C + peer_slot(cx, dx);
        py = C + (K - 1) + peer_slot(cy, dy);
        port_xy = (cx != dx) ? PW'(px) : PW'(py);
        port_yx = (cy != dy) ? PW'(py) : PW'(px);
        at_dest = (cur_rtr == dst_rtr);
    end
endmodule

// File: rtl/ffly_vc_window.sv
module ffly_vc_window
    import ffly_route_pkg::*;
#(
    parameter int NVC    = 8,
    parameter int VW     = 3,
    parameter int RDQ_LO = 0, parameter int RDQ_HI = 3,
    parameter int WRQ_LO = 4, parameter int WRQ_HI = 5,
    parameter int RDP_LO = 6, parameter int RDP_HI = 7,
    parameter int WRP_LO = 4, parameter int WRP_HI = 7
) (
    input  flit_cls_e     cls,
    input  win_mode_e     mode,
    input  logic [VW-1:0] cur_vc,
    output logic [VW-1:0] win_lo,
    output logic [VW-1:0] win_hi,
    output logic          cur_in_low
);
    always_comb begin
        int lo, hi, half;
        unique case (cls)
            CLS_RD_REQ: begin lo = RDQ_LO; hi = RDQ_HI; end
            CLS_WR_REQ: begin lo = WRQ_LO; hi = WRQ_HI; end
            CLS_RD_RSP: begin lo = RDP_LO; hi = RDP_HI; end
            CLS_WR_RSP: begin lo = WRP_LO; hi = WRP_HI; end
            default:    begin lo = 0;      hi = NVC - 1; end
        endcase
        half = (hi - lo + 1) / 2;
        cur_in_low = int'(cur_vc) < (lo + half);
        unique case (mode)
            WIN_LOW:  begin win_lo = VW'(lo);        win_hi = VW'(lo + half - 1); end
            WIN_HIGH: begin win_lo = VW'(lo + half); win_hi = VW'(hi);            end
            default:  begin win_lo = VW'(lo);        win_hi = VW'(hi);            end
        endcase
    end
endmodule

// File: rtl/ffly_order_pick.sv
module ffly_order_pick
    import ffly_route_pkg::*;
#(
    parameter int NP = 8,
    parameter int PW = 3,
    parameter int CW = 4,
    parameter int C  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic [PW-1:0]  in_chan,
    input  logic [PW-1:0]  port_xy,
    input  logic [PW-1:0]  port_yx,
    input  logic [NP*CW-1:0] used_credits,
    input  logic           cur_in_low,
    output logic           use_xy
);
    logic [15:0]   tie_q;
    logic [CW-1:0] load_xy, load_yx;
    logic          from_terminal;

    always_ff @(posedge clk) begin
        if (rst)          tie_q <= TIE_SEED;
        else if (advance) tie_q <= tie_step(tie_q);
    end

    assign load_xy       = used_credits[port_xy*CW +: CW];
    assign load_yx       = used_credits[port_yx*CW +: CW];
    assign from_terminal = (in_chan < PW'(C));

    always_comb begin
        if (!from_terminal)          use_xy = cur_in_low;
        else if (load_xy < load_yx)  use_xy = 1'b1;
        else if (load_xy > load_yx)  use_xy = 1'b0;
        else                         use_xy = tie_q[0];
    end

    // R7: the tie-break register never locks up in the all-zero state
    a_r7_tie_live: assert property (@(posedge clk) disable iff (rst)
        tie_q != 16'h0000);
endmodule

// File: rtl/ffly_route_sel.sv
module ffly_route_sel
    import ffly_route_pkg::*;
#(
    parameter int K      = 4,
    parameter int C      = 2,
    parameter int NVC    = 8,
    parameter int CW     = 4,
    parameter int RDQ_LO = 0, parameter int RDQ_HI = 3,
    parameter int WRQ_LO = 4, parameter int WRQ_HI = 5,
    parameter int RDP_LO = 6, parameter int RDP_HI = 7,
    parameter int WRP_LO = 4, parameter int WRP_HI = 7,
    localparam int NR = K * K,
    localparam int NT = NR * C,
    localparam int NP = C + 2 * (K - 1),
    localparam int RW = $clog2(NR),
    localparam int DW = $clog2(NT),
    localparam int PW = $clog2(NP),
    localparam int VW = $clog2(NVC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [RW-1:0]    req_rtr,
    input  logic [DW-1:0]    req_dest,
    input  logic [PW-1:0]    req_in_chan,
    input  logic [VW-1:0]    req_vc,
    input  logic [2:0]       req_cls,
    input  logic             req_src_inject,
    input  logic [NP*CW-1:0] used_credits,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PW-1:0]    rsp_port,
    output logic [VW-1:0]    rsp_vc_lo,
    output logic [VW-1:0]    rsp_vc_hi,
    output logic             rsp_xy,
    output logic             rsp_eject,
    output logic             rsp_no_route
);
    typedef struct packed {
        logic [PW-1:0] port;
        logic [VW-1:0] lo;
        logic [VW-1:0] hi;
        logic          xy;
        logic          eject;
        logic          none;
    } route_t;

    logic [RW-1:0] dst_rtr;
    logic [PW-1:0] port_xy, port_yx, eject_port;
    logic          at_dest, use_xy, cur_in_low, accept;
    logic [VW-1:0] win_lo, win_hi;
    win_mode_e     mode;
    route_t        nxt, res_q;

    assign dst_rtr    = RW'(int'(req_dest) / C);
    assign eject_port = PW'(int'(req_dest) % C);
    assign req_ready  = !rsp_valid || rsp_ready;
    assign accept     = req_valid && req_ready;

    ffly_port_calc #(.K(K), .C(C), .RW(RW), .PW(PW)) u_ports (
        .cur_rtr (req_rtr),
        .dst_rtr (dst_rtr),
        .port_xy (port_xy),
        .port_yx (port_yx),
        .at_dest (at_dest)
    );

    ffly_order_pick #(.NP(NP), .PW(PW), .CW(CW), .C(C)) u_pick (
        .clk          (clk),
        .rst          (rst),
        .advance      (accept),
        .in_chan      (req_in_chan),
        .port_xy      (port_xy),
        .port_yx      (port_yx),
        .used_credits (used_credits),
        .cur_in_low   (cur_in_low),
        .use_xy       (use_xy)
    );

    always_comb begin
        if (req_src_inject || at_dest) mode = WIN_FULL;
        else if (use_xy)               mode = WIN_LOW;
        else                           mode = WIN_HIGH;
    end

    ffly_vc_window #(
        .NVC(NVC), .VW(VW),
        .RDQ_LO(RDQ_LO), .RDQ_HI(RDQ_HI), .WRQ_LO(WRQ_LO), .WRQ_HI(WRQ_HI),
        .RDP_LO(RDP_LO), .RDP_HI(RDP_HI), .WRP_LO(WRP_LO), .WRP_HI(WRP_HI)
    ) u_win (
        .cls        (flit_cls_e'(req_cls)),
        .mode       (mode),
        .cur_vc     (req_vc),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .cur_in_low (cur_in_low)
    );

    always_comb begin
        nxt       = '0;
        nxt.lo    = win_lo;
        nxt.hi    = win_hi;
        if (req_src_inject) begin
            nxt.none = 1'b1;
        end else if (at_dest) begin
            nxt.port  = eject_port;
            nxt.eject = 1'b1;
        end else begin
            nxt.port = use_xy ? port_xy : port_yx;
            nxt.xy   = use_xy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            res_q     <= nxt;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_port     = res_q.port;
    assign rsp_vc_lo    = res_q.lo;
    assign rsp_vc_hi    = res_q.hi;
    assign rsp_xy       = res_q.xy;
    assign rsp_eject    = res_q.eject;
    assign rsp_no_route = res_q.none;

    // R11: reset empties the output stage
    a_r11_reset_idle: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R10: an untaken result is held unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_port)
            && $stable(rsp_vc_lo) && $stable(rsp_vc_hi) && $stable(rsp_xy));

    // R1: ejection only ever targets a terminal port
    a_r1_eject_port: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_eject |-> rsp_port < PW'(C));

    // R3: a network hop never targets a terminal port
    a_r3_net_port: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_eject && !rsp_no_route |-> rsp_port >= PW'(C));

    // R5: the VC window is never empty
    a_r5_window_order: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_vc_lo <= rsp_vc_hi);

    // R9: flags are mutually exclusive
    a_r9_flags: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_eject, rsp_no_route, rsp_xy}) <= 1);
endmodule

// File: tb/ffly_route_sel_tb.sv
module ffly_route_sel_tb;
    localparam int K = 4, C = 2, NVC = 8, CW = 4;
    localparam int NP = C + 2 * (K - 1);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_src_inject = 1'b0;
    logic [3:0] req_rtr = '0;
    logic [4:0] req_dest = '0;
    logic [2:0] req_in_chan = '0, req_vc = '0, req_cls = '0;
    logic [NP*CW-1:0] used_credits = '0;
    logic rsp_valid, rsp_ready = 1'b1, rsp_xy, rsp_eject, rsp_no_route;
    logic [2:0] rsp_port, rsp_vc_lo, rsp_vc_hi;

    int n_tests = 0, n_fail = 0;
    logic [15:0] tie_m = 16'hACE1;
    bit done = 0;

    always #2.5 clk = ~clk;

    ffly_route_sel u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rtr(req_rtr), .req_dest(req_dest), .req_in_chan(req_in_chan),
        .req_vc(req_vc), .req_cls(req_cls), .req_src_inject(req_src_inject),
        .used_credits(used_credits), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_port(rsp_port), .rsp_vc_lo(rsp_vc_lo), .rsp_vc_hi(rsp_vc_hi),
        .rsp_xy(rsp_xy), .rsp_eject(rsp_eject), .rsp_no_route(rsp_no_route)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void cls_range(input int cls, output int lo, output int hi);
        case (cls)
            1: begin lo = 0; hi = 3; end
            2: begin lo = 4; hi = 5; end
            3: begin lo = 6; hi = 7; end
            4: begin lo = 4; hi = 7; end
            default: begin lo = 0; hi = NVC - 1; end
        endcase
    endfunction

    function automatic int slot(input int own, input int o);
        return (o < own) ? o : o - 1;
    endfunction

    function automatic logic [15:0] tie_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic set_credit(input int port, input int val);
        used_credits[port*CW +: CW] = CW'(val);
    endtask

    // expected result of one request, from the requirements
    task automatic predict(input int rtr, input int dest, input int inch, input int vc,
                           input int cls, input bit srcinj,
                           output int port, output int lo, output int hi,
                           output int xy, output int ej, output int nr);
        int clo, chi, half, dr, cx, cy, dx, dy, pxy, pyx, lx, ly;
        bit pick;
        cls_range(cls, clo, chi);
        half = (chi - clo + 1) / 2;
        dr = dest / C;
        port = 0; lo = clo; hi = chi; xy = 0; ej = 0; nr = 0;
        if (srcinj) begin
            nr = 1;
        end else if (dr == rtr) begin
            port = dest % C; ej = 1;
        end else begin
            cx = rtr % K; cy = rtr / K; dx = dr % K; dy = dr / K;
            pxy = (cx != dx) ? C + slot(cx, dx) : C + K - 1 + slot(cy, dy);
            pyx = (cy != dy) ? C + K - 1 + slot(cy, dy) : C + slot(cx, dx);
            if (inch >= C) pick = (vc < clo + half);
            else begin
                lx = int'(used_credits[pxy*CW +: CW]);
                ly = int'(used_credits[pyx*CW +: CW]);
                pick = (lx < ly) ? 1'b1 : (lx > ly) ? 1'b0 : tie_m[0];
            end
            xy = pick;
            port = pick ? pxy : pyx;
            if (pick) hi = clo + half - 1; else lo = clo + half;
        end
    endtask

    task automatic apply(input int rtr, input int dest, input int inch, input int vc,
                         input int cls, input bit srcinj);
        req_rtr = 4'(rtr); req_dest = 5'(dest); req_in_chan = 3'(inch);
        req_vc = 3'(vc); req_cls = 3'(cls); req_src_inject = srcinj;
        req_valid = 1'b1;
    endtask

    task automatic compare(input string tag, input int port, input int lo, input int hi,
                           input int xy, input int ej, input int nr);
        chk({tag, " valid"}, int'(rsp_valid), 1);
        chk({tag, " port"},  int'(rsp_port), port);
        chk({tag, " vc_lo"}, int'(rsp_vc_lo), lo);
        chk({tag, " vc_hi"}, int'(rsp_vc_hi), hi);
        chk({tag, " xy"},    int'(rsp_xy), xy);
        chk({tag, " eject"}, int'(rsp_eject), ej);
        chk({tag, " noroute"}, int'(rsp_no_route), nr);
    endtask

    // one request, accepted at once, checked one cycle later
    task automatic route(input string tag, input int rtr, input int dest, input int inch,
                         input int vc, input int cls, input bit srcinj);
        int p, lo, hi, xy, ej, nr;
        @(negedge clk);
        apply(rtr, dest, inch, vc, cls, srcinj);
        predict(rtr, dest, inch, vc, cls, srcinj, p, lo, hi, xy, ej, nr);
        @(posedge clk);
        tie_m = tie_next(tie_m);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag, p, lo, hi, xy, ej, nr);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R11 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_eject;
        route("R1 eject port1 rdreq", 5, 11, 4, 1, 1, 0);
        route("R1 eject port0 any class R2", 9, 18, 0, 0, 0, 0);
    endtask

    task automatic t_inject_load;
        used_credits = '0;
        set_credit(3, 1); set_credit(7, 5);
        route("R6 R3 R5 inject xy lighter", 5, 29, 0, 0, 1, 0);
        set_credit(3, 9);
        route("R6 R4 inject yx lighter", 5, 29, 1, 0, 1, 0);
        used_credits = '0;
    endtask

    task automatic t_ties;
        used_credits = '0;
        for (int i = 0; i < 4; i++) route("R7 tie break", 0, 31, 0, 0, 3, 0);
    endtask

    task automatic t_network;
        route("R8 net xy rdreq vc1", 5, 29, 4, 1, 1, 0);
        route("R8 net yx rdreq vc2", 5, 29, 4, 2, 1, 0);
        route("R8 net xy wrrsp vc5 R2", 2, 20, 6, 5, 4, 0);
        route("R8 net yx wrrsp vc6 R2", 2, 20, 6, 6, 4, 0);
        route("R8 net yx wrreq vc5 R2", 12, 1, 3, 5, 2, 0);
        route("R8 net any class vc3 R5", 7, 10, 5, 3, 7, 0);
    endtask

    task automatic t_single_dim;
        set_credit(4, 2); set_credit(6, 2);
        route("R4 same row, x only", 4, 14, 0, 0, 3, 0);
        route("R4 same column, y only", 1, 27, 2, 6, 3, 0);
        used_credits = '0;
    endtask

    task automatic t_noroute;
        route("R9 source inject", 5, 29, 0, 0, 2, 1);
    endtask

    // hold under backpressure, then drain and accept on one edge
    task automatic t_overlap;
        int pa, la, ha, xa, ea, na, pb, lb, hb, xb, eb, nb;
        @(negedge clk);
        rsp_ready = 1'b0;
        apply(6, 3, 4, 0, 1, 0);
        predict(6, 3, 4, 0, 1, 0, pa, la, ha, xa, ea, na);
        @(posedge clk);
        tie_m = tie_next(tie_m);
        @(negedge clk);
        apply(3, 24, 5, 3, 1, 0);
        predict(3, 24, 5, 3, 1, 0, pb, lb, hb, xb, eb, nb);
        compare("R10 first result", pa, la, ha, xa, ea, na);
        chk("R10 ready low while held", int'(req_ready), 0);
        @(negedge clk);
        compare("R10 held stable", pa, la, ha, xa, ea, na);
        rsp_ready = 1'b1;
        @(posedge clk);
        tie_m = tie_next(tie_m);
        @(negedge clk);
        req_valid = 1'b0;
        compare("R10 back-to-back second", pb, lb, hb, xb, eb, nb);
        @(negedge clk);
        chk("R10 drained", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_eject();
        t_inject_load();
        t_ties();
        t_network();
        t_single_dim();
        t_noroute();
        t_overlap();
        t_ties();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule